// File: doc/BRIEF.md
# Segment Table Address Translator

This block converts a two-part logical address, made of a segment number and a byte offset, into a physical address. The conversion uses a small table of segment descriptors held in registers inside the block. Each descriptor holds four things: the physical start of the segment, its length, a present flag and three access-right bits. A separate register holds how many segments are currently in use.

A requester raises a one-cycle strobe with the segment number, the offset and the kind of access. One cycle later the block returns a done strobe. With it comes either the translated address or a fault code naming the single most important reason the access was refused.

Software fills the descriptors and the in-use count through a simple write port. A write made in the same cycle as a request does not change the result of that request.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, `done_o`, `paddr_o` and `fault_o` are zero, every descriptor is marked not present, and the in-use count is zero, so any request then faults with the range code.
- R2: `done_o` is high exactly in the cycle after a cycle with `req_i` high. In every other cycle `done_o`, `paddr_o` and `fault_o` are all zero.
- R3: A request whose segment number is greater than or equal to the in-use count returns fault code 1.
- R4: A request to a descriptor whose present flag is 0 returns fault code 2.
- R5: A request whose offset is greater than or equal to the descriptor's length returns fault code 3. A length of 0 faults for every offset.
- R6: Access codes are 0 for read, 1 for write and 2 for execute. Each needs its right bit in the descriptor: bit 0 for read, bit 1 for write, bit 2 for execute. Code 3 is always refused. A refused access returns fault code 4.
- R7: When several faults apply, only one code is reported, in this order of priority: 1, then 2, then 3, then 4.
- R8: A legal request returns fault code 0 and `paddr_o` equal to base plus offset, modulo 2^PA_W.
- R9: Whenever the fault code is non-zero, `paddr_o` is zero.
- R10: A descriptor or count write in the same cycle as a request takes effect only for later requests.
- R11: A write with `wr_cnt_i` high loads the in-use count from `wr_cnt_val_i`. Values above NUM_SEG saturate to NUM_SEG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Translation request strobe |
| seg_i | input | SEG_W | Segment number |
| off_i | input | OFF_W | Offset within segment |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| done_o | output | 1 | Result valid strobe |
| paddr_o | output | PA_W | Physical address, zero on fault |
| fault_o | output | 3 | Fault code: 0 none, 1 range, 2 not present, 3 length, 4 rights |
| wr_en_i | input | 1 | Table write strobe |
| wr_cnt_i | input | 1 | Selects the in-use count instead of a descriptor |
| wr_idx_i | input | SEG_W | Descriptor index |
| wr_base_i | input | PA_W | Descriptor base |
| wr_lim_i | input | OFF_W+1 | Descriptor length |
| wr_valid_i | input | 1 | Descriptor present flag |
| wr_perm_i | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| wr_cnt_val_i | input | SEG_W+1 | New in-use count |

## Verification
Several properties are checked on every cycle by the assertions: the one-cycle strobe timing, the quiet outputs between results, the zero address on any fault, the range fault against the live count, and the count bound. The following can only be shown by the bench's scenarios against its reference model: the full priority order among the four faults, the modular address sum, how each access code maps to its right bit, and writes colliding with requests.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_RANGE   = 3'd1,
      FLT_ABSENT  = 3'd2,
      FLT_LENGTH  = 3'd3,
      FLT_RIGHTS  = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } access_e;

   localparam int RIGHT_R = 0;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 2;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
   parameter int NUM_SEG = 16,
   parameter int SEG_W   = 4,
   parameter int OFF_W   = 10,
   parameter int PA_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic               wr_cnt_i,
   input  logic [SEG_W-1:0]   wr_idx_i,
   input  logic [PA_W-1:0]    wr_base_i,
   input  logic [OFF_W:0]     wr_lim_i,
   input  logic               wr_valid_i,
   input  logic [2:0]         wr_perm_i,
   input  logic [SEG_W:0]     wr_cnt_val_i,
   input  logic [SEG_W-1:0]   rd_idx_i,
   output logic [PA_W-1:0]    rd_base_o,
   output logic [OFF_W:0]     rd_lim_o,
   output logic               rd_valid_o,
   output logic [2:0]         rd_perm_o,
   output logic [SEG_W:0]     cnt_o
);
   localparam int CNT_W = SEG_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_SEG);

   logic [PA_W-1:0] base_a  [NUM_SEG];
   logic [OFF_W:0]  lim_a   [NUM_SEG];
   logic            valid_a [NUM_SEG];
   logic [2:0]      perm_a  [NUM_SEG];
   logic [CNT_W-1:0] cnt_q;

   for (genvar e = 0; e < NUM_SEG; e++) begin : g_ent
      logic [PA_W-1:0] base_q;
      logic [OFF_W:0]  lim_q;
      logic            valid_q;
      logic [2:0]      perm_q;
      logic            hit;
      assign hit = wr_en_i && !wr_cnt_i && (wr_idx_i == SEG_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q  <= '0;
            lim_q   <= '0;
            valid_q <= 1'b0;
            perm_q  <= '0;
         end else if (hit) begin
            base_q  <= wr_base_i;
            lim_q   <= wr_lim_i;
            valid_q <= wr_valid_i;
            perm_q  <= wr_perm_i;
         end
      end
      assign base_a[e]  = base_q;
      assign lim_a[e]   = lim_q;
      assign valid_a[e] = valid_q;
      assign perm_a[e]  = perm_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wr_en_i && wr_cnt_i)
         cnt_q <= (wr_cnt_val_i > CNT_MAX) ? CNT_MAX : wr_cnt_val_i;
   end

   assign rd_base_o  = base_a[rd_idx_i];
   assign rd_lim_o   = lim_a[rd_idx_i];
   assign rd_valid_o = valid_a[rd_idx_i];
   assign rd_perm_o  = perm_a[rd_idx_i];
   assign cnt_o      = cnt_q;

   // R11: the in-use count never exceeds the table size
   p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
endmodule

// File: rtl/seg_rule_chk.sv
module seg_rule_chk
   import seg_xlat_pkg::*;
#(
   parameter int SEG_W = 4,
   parameter int OFF_W = 10,
   parameter int PA_W  = 16
) (
   input  logic [SEG_W-1:0] seg_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [1:0]       acc_i,
   input  logic [SEG_W:0]   cnt_i,
   input  logic [PA_W-1:0]  base_i,
   input  logic [OFF_W:0]   lim_i,
   input  logic             valid_i,
   input  logic [2:0]       perm_i,
   output fault_e           fault_o,
   output logic [PA_W-1:0]  sum_o
);
   logic rights_ok;

   always_comb begin
      unique case (access_e'(acc_i))
         ACC_READ:  rights_ok = perm_i[RIGHT_R];
         ACC_WRITE: rights_ok = perm_i[RIGHT_W];
         ACC_EXEC:  rights_ok = perm_i[RIGHT_X];
         default:   rights_ok = 1'b0;
      endcase
   end

   always_comb begin
      if ({1'b0, seg_i} >= cnt_i)       fault_o = FLT_RANGE;
      else if (!valid_i)                fault_o = FLT_ABSENT;
      else if ({1'b0, off_i} >= lim_i)  fault_o = FLT_LENGTH;
      else if (!rights_ok)              fault_o = FLT_RIGHTS;
      else                              fault_o = FLT_NONE;
   end

   assign sum_o = base_i + PA_W'(off_i);
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
   import seg_xlat_pkg::*;
#(
   parameter int NUM_SEG = 16,
   parameter int OFF_W   = 10,
   parameter int PA_W    = 16,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [SEG_W-1:0]   seg_i,
   input  logic [OFF_W-1:0]   off_i,
   input  logic [1:0]         acc_i,
   output logic               done_o,
   output logic [PA_W-1:0]    paddr_o,
   output logic [2:0]         fault_o,
   input  logic               wr_en_i,
   input  logic               wr_cnt_i,
   input  logic [SEG_W-1:0]   wr_idx_i,
   input  logic [PA_W-1:0]    wr_base_i,
   input  logic [OFF_W:0]     wr_lim_i,
   input  logic               wr_valid_i,
   input  logic [2:0]         wr_perm_i,
   input  logic [SEG_W:0]     wr_cnt_val_i
);
   if (NUM_SEG < 2 || (1 << SEG_W) != NUM_SEG) begin : g_bad_num
      $error("NUM_SEG must be a power of two of at least 2");
   end
   if (PA_W < OFF_W) begin : g_bad_pa
      $error("PA_W must be at least OFF_W");
   end

   logic [PA_W-1:0] t_base;
   logic [OFF_W:0]  t_lim;
   logic            t_valid;
   logic [2:0]      t_perm;
   logic [SEG_W:0]  t_cnt;
   fault_e          c_fault;
   logic [PA_W-1:0] c_sum;

   seg_desc_table #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_cnt_i(wr_cnt_i), .wr_idx_i(wr_idx_i),
      .wr_base_i(wr_base_i), .wr_lim_i(wr_lim_i), .wr_valid_i(wr_valid_i),
      .wr_perm_i(wr_perm_i), .wr_cnt_val_i(wr_cnt_val_i),
      .rd_idx_i(seg_i), .rd_base_o(t_base), .rd_lim_o(t_lim),
      .rd_valid_o(t_valid), .rd_perm_o(t_perm), .cnt_o(t_cnt)
   );

   seg_rule_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_rules (
      .seg_i(seg_i), .off_i(off_i), .acc_i(acc_i), .cnt_i(t_cnt),
      .base_i(t_base), .lim_i(t_lim), .valid_i(t_valid), .perm_i(t_perm),
      .fault_o(c_fault), .sum_o(c_sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         paddr_o <= '0;
         fault_o <= '0;
      end else begin
         done_o  <= req_i;
         fault_o <= req_i ? c_fault : FLT_NONE;
         paddr_o <= (req_i && c_fault == FLT_NONE) ? c_sum : '0;
      end
   end

   // R2: a request yields done in the following cycle
   p_done_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> done_o);
   // R2: no request, no result strobe
   p_no_spur_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !done_o);
   // R2: outputs stay quiet between results
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (paddr_o == '0 && fault_o == '0));
   // R9: a faulting result carries no address
   p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o != '0) |-> paddr_o == '0);
   // R3: out-of-range segment against the live count reports the range code
   p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && ({1'b0, seg_i} >= t_cnt)) |=> fault_o == 3'd1);
endmodule

// File: tb/seg_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlat_unit_tb_top;
   localparam int NSEG = 16;
   localparam int SW   = 4;
   localparam int OW   = 10;
   localparam int PW   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic [SW-1:0] seg_i = '0;
   logic [OW-1:0] off_i = '0;
   logic [1:0] acc_i = '0;
   logic done_o;
   logic [PW-1:0] paddr_o;
   logic [2:0] fault_o;
   logic wr_en_i = 1'b0, wr_cnt_i = 1'b0, wr_valid_i = 1'b0;
   logic [SW-1:0] wr_idx_i = '0;
   logic [PW-1:0] wr_base_i = '0;
   logic [OW:0] wr_lim_i = '0;
   logic [2:0] wr_perm_i = '0;
   logic [SW:0] wr_cnt_val_i = '0;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   int m_base [NSEG];
   int m_lim [NSEG];
   int m_valid [NSEG];
   int m_perm [NSEG];
   int m_cnt;

   always #2 clk = ~clk;

   seg_xlat_unit #(.NUM_SEG(NSEG), .OFF_W(OW), .PA_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .seg_i(seg_i), .off_i(off_i),
      .acc_i(acc_i), .done_o(done_o), .paddr_o(paddr_o), .fault_o(fault_o),
      .wr_en_i(wr_en_i), .wr_cnt_i(wr_cnt_i), .wr_idx_i(wr_idx_i),
      .wr_base_i(wr_base_i), .wr_lim_i(wr_lim_i), .wr_valid_i(wr_valid_i),
      .wr_perm_i(wr_perm_i), .wr_cnt_val_i(wr_cnt_val_i)
   );

   task automatic check(string tag, int act_d, int exp_d, int act_f, int exp_f,
                        int act_a, int exp_a);
      total++;
      if (act_d != exp_d || act_f != exp_f || act_a != exp_a) begin
         bad++;
         $display("FAIL %s actual done=%0d fault=%0d paddr=%h expected done=%0d fault=%0d paddr=%h",
                  tag, act_d, act_f, act_a, exp_d, exp_f, exp_a);
      end
   endtask

   function automatic int exp_fault(int s, int o, int a);
      int ok;
      if (s >= m_cnt) return 1;
      if (m_valid[s] == 0) return 2;
      if (o >= m_lim[s]) return 3;
      ok = (a == 3) ? 0 : ((m_perm[s] >> a) & 1);
      if (ok == 0) return 4;
      return 0;
   endfunction

   // One cycle, entered and left at a falling edge
   task automatic step(string tag, bit rq, int s, int o, int a,
                       bit we, bit wc, int wi, int wb, int wl, int wv, int wp, int wcv);
      int ef, ea, ed;
      req_i = rq; seg_i = SW'(s); off_i = OW'(o); acc_i = 2'(a);
      wr_en_i = we; wr_cnt_i = wc; wr_idx_i = SW'(wi); wr_base_i = PW'(wb);
      wr_lim_i = (OW+1)'(wl); wr_valid_i = wv[0]; wr_perm_i = 3'(wp);
      wr_cnt_val_i = (SW+1)'(wcv);
      ed = rq ? 1 : 0;
      ef = rq ? exp_fault(s, o, a) : 0;
      ea = (rq && ef == 0) ? ((m_base[s] + o) % (1 << PW)) : 0;
      @(posedge clk);
      if (we) begin
         if (wc) m_cnt = (wcv > NSEG) ? NSEG : wcv;
         else begin
            m_base[wi] = wb; m_lim[wi] = wl; m_valid[wi] = wv; m_perm[wi] = wp;
         end
      end
      @(negedge clk);
      check(tag, int'(done_o), ed, int'(fault_o), ef, int'(paddr_o), ea);
   endtask

   task automatic req(string tag, int s, int o, int a);
      step(tag, 1, s, o, a, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr_ent(int i, int b, int l, int v, int p);
      step("R2", 0, 0, 0, 0, 1, 0, i, b, l, v, p, 0);
   endtask

   task automatic wr_count(string tag, int c);
      step(tag, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, c);
   endtask

   initial begin
      int limit_cycles = 20000;
      while (cycles < limit_cycles) begin
         @(posedge clk);
         cycles++;
      end
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NSEG; i++) begin
         m_base[i] = 0; m_lim[i] = 0; m_valid[i] = 0; m_perm[i] = 0;
      end
      m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1", int'(done_o), 0, int'(fault_o), 0, int'(paddr_o), 0);
      req("R1", 0, 0, 0);
      req("R3", 3, 5, 0);
      step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

      wr_count("R11", 4);
      wr_ent(0, 'h0100, 'h040, 1, 7);
      wr_ent(1, 'h0200, 'h100, 0, 7);
      wr_ent(2, 'h0300, 'h010, 1, 1);
      wr_ent(3, 'hFFF0, 'h020, 1, 7);
      wr_ent(5, 'h0500, 'h010, 0, 0);
      wr_ent(6, 'h0600, 'h000, 1, 7);

      req("R8", 0, 'h03F, 0);
      req("R8", 0, 'h000, 2);
      req("R5", 0, 'h040, 1);
      req("R9", 0, 'h3FF, 0);
      req("R4", 1, 'h005, 0);
      req("R7", 1, 'h3FF, 3);
      req("R6", 2, 'h004, 1);
      req("R6", 2, 'h004, 2);
      req("R6", 2, 'h004, 3);
      req("R6", 2, 'h004, 0);
      req("R7", 2, 'h010, 1);
      req("R8", 3, 'h018, 0);
      req("R3", 4, 'h000, 0);
      req("R7", 5, 'h3FF, 3);

      // R10: same-cycle write is invisible to the request
      step("R10", 1, 0, 'h010, 0, 1, 0, 0, 'h0A00, 'h040, 1, 7, 0);
      req("R10", 0, 'h010, 0);
      step("R10", 1, 6, 0, 0, 1, 1, 0, 0, 0, 0, 0, 7);
      req("R5", 6, 0, 0);

      wr_count("R11", 31);
      wr_ent(15, 'h1234, 'h7FF, 1, 4);
      req("R11", 15, 'h3FF, 2);
      wr_count("R11", 16);
      req("R11", 15, 'h001, 2);
      wr_count("R11", 0);
      req("R3", 0, 0, 0);

      wr_count("R11", 10);
      for (int k = 0; k < 600; k++) begin
         if (($urandom % 8) == 0)
            step("R7", $urandom % 2, $urandom % NSEG, $urandom % 64, $urandom % 4,
                 1, ($urandom % 6) == 0, $urandom % NSEG, $urandom % 65536,
                 $urandom % 64, $urandom % 4 != 0, $urandom % 8, $urandom % 20);
         else
            step("R7", ($urandom % 4) != 0, $urandom % NSEG, $urandom % 64,
                 $urandom % 4, 0, 0, 0, 0, 0, 0, 0, 0);
      end
      step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule